// File: doc/BRIEF.md
# Slow-Tick Uptime Counter with Alarm

This block is an always-on uptime timer. A slow reference clock reaches it as a one-cycle enable strobe on the system clock. A programmable prescaler divides that strobe, and each prescaler wrap advances a free-running counter by one. With the default divisor of 32768, a 32.768 kHz reference gives one count per second. Software cannot load the counter. It can only zero it, by writing the control word with a self-clearing restart bit set.

An alarm register is compared against the counter. The all-ones alarm value means that no alarm is armed. Two sticky flags record events: one for an alarm match and one for each counter advance. The flags are read through a status word, and reading it clears them. Each flag has an interrupt enable that sits exactly sixteen bit positions above it in the control word. The masked flags are ORed onto one level-sensitive interrupt line.

Reads return a registered snapshot, so one read cycle always sees a single consistent counter value. Software that compares two reads can then resolve an update in flight.

Top module: `uptime_alarm_timer`

## Requirements
- R1: After reset, the control word (address 0) reads 0x00008000 (divisor 32768, both enables 0). The counter (address 1) reads 0, the alarm (address 2) reads 0xFFFFFFFF, the status (address 3) reads 0, and `irq` is low.
- R2: With divisor P in control bits [15:0], the counter advances once every P cycles in which `tick_en` is high. A divisor of 0 or 1 advances it on every such cycle, and cycles with `tick_en` low are not counted.
- R3: A write to the counter address (1) has no effect on the counter.
- R4: Writing the control word with bit 18 set zeroes the counter and the prescaler phase, and the newly written divisor and enables take effect. Bit 18 always reads back as 0.
- R5: Status bit 1 (increment flag) is set on every counter advance.
- R6: Status bit 0 (alarm flag) is set when an advance brings the counter to a value equal to the alarm register, provided that value is not 0xFFFFFFFF. The flag is not set again while the counter holds that value.
- R7: A read of the status word returns both flags and clears them. A flag that is set in the same cycle as the clearing read is kept.
- R8: `irq` is high exactly while (status bit 0 AND control bit 16) OR (status bit 1 AND control bit 17).
- R9: `bus_rd_data` shows the addressed register as it was in the `bus_rd_en` cycle, from the next cycle on, and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe per slow reference clock period |
| bus_addr | input | 2 | Register word address |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe; a read of the status word clears the flags |
| bus_rd_data | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, masked flags ORed |

## Verification
The hardest case to reach from the ports is a status read in the same system-clock cycle as a counter advance. It requires a divisor of 1 and a read strobe placed on the exact cycle of a slow tick. The stimulus drives both strobes on one falling edge. It then expects the read to return the pre-advance flags and a second read to find the increment flag still set. Restart from a mid-phase prescaler is also checked: ticks are first accumulated under the large default divisor, and the bench then shows that a smaller new divisor does not wrap early.

// File: rtl/uat_pkg.sv
package uat_pkg;
   localparam int ALM_EN_BIT   = 16;
   localparam int INC_EN_BIT   = 17;
   localparam int RESTART_BIT  = 18;
   localparam int ENABLE_SHIFT = 16;
   localparam int NUM_FLAGS    = 2;
   localparam int FLAG_ALM     = 0;
   localparam int FLAG_INC     = 1;

   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_COUNT  = 2'd1,
      SEL_ALARM  = 2'd2,
      SEL_STATUS = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/uat_prescaler.sv
module uat_prescaler #(
   parameter int PRE_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             restart,
   input  logic [PRE_W-1:0] divisor,
   output logic             wrap
);
   logic [PRE_W-1:0] phase_q;
   logic [PRE_W:0]   phase_inc;

   assign phase_inc = {1'b0, phase_q} + {{PRE_W{1'b0}}, 1'b1};
   assign wrap      = tick_en && !restart && (phase_inc >= {1'b0, divisor});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase_q <= '0;
      else if (restart) phase_q <= '0;
      else if (tick_en) phase_q <= wrap ? '0 : phase_inc[PRE_W-1:0];
   end
endmodule

// File: rtl/uat_counter.sv
module uat_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic             restart,
   input  logic [CNT_W-1:0] alarm_val,
   output logic [CNT_W-1:0] count,
   output logic             alarm_hit
);
   logic [CNT_W-1:0] count_next;
   logic             alarm_armed;

   assign count_next  = count + {{(CNT_W-1){1'b0}}, 1'b1};
   assign alarm_armed = ~&alarm_val;
   assign alarm_hit   = advance && alarm_armed && (count_next == alarm_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count <= '0;
      else if (restart) count <= '0;
      else if (advance) count <= count_next;
   end
endmodule

// File: rtl/uat_status.sv
module uat_status
   import uat_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_FLAGS-1:0] set_vec,
   input  logic [NUM_FLAGS-1:0] en_vec,
   input  logic                 clear,
   output logic [NUM_FLAGS-1:0] flags,
   output logic                 irq
);
   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags[i] <= 1'b0;
         else        flags[i] <= (flags[i] & ~clear) | set_vec[i];
      end
   end

   assign irq = |(flags & en_vec);
endmodule

// File: rtl/uat_regs.sv
module uat_regs
   import uat_pkg::*;
#(
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 2,
   parameter int          CNT_W     = 32,
   parameter int          PRE_W     = 16,
   parameter int unsigned PRE_RESET = 32768,
   parameter bit          SNAPSHOT  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 wr_en,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 rd_en,
   output logic [DATA_W-1:0]    rd_data,
   input  logic [CNT_W-1:0]     count,
   input  logic [NUM_FLAGS-1:0] flags,
   output logic [PRE_W-1:0]     divisor,
   output logic [NUM_FLAGS-1:0] en_vec,
   output logic [CNT_W-1:0]     alarm_val,
   output logic                 restart,
   output logic                 status_clear
);
   localparam logic [PRE_W-1:0] DIV_INIT = PRE_W'(PRE_RESET);

   logic              hit_ctrl, hit_alarm, hit_status, hit_count;
   logic [DATA_W-1:0] ctrl_view, rd_mux;
   logic              unused_wd;

   assign unused_wd  = ^wr_data;
   assign hit_ctrl   = (addr == ADDR_W'(SEL_CTRL));
   assign hit_count  = (addr == ADDR_W'(SEL_COUNT));
   assign hit_alarm  = (addr == ADDR_W'(SEL_ALARM));
   assign hit_status = (addr == ADDR_W'(SEL_STATUS));

   assign restart      = wr_en && hit_ctrl && wr_data[RESTART_BIT];
   assign status_clear = rd_en && hit_status;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         divisor   <= DIV_INIT;
         en_vec    <= '0;
         alarm_val <= '1;
      end else if (wr_en) begin
         if (hit_ctrl) begin
            divisor          <= wr_data[PRE_W-1:0];
            en_vec[FLAG_ALM] <= wr_data[ALM_EN_BIT];
            en_vec[FLAG_INC] <= wr_data[INC_EN_BIT];
         end
         if (hit_alarm) alarm_val <= wr_data[CNT_W-1:0];
      end
   end

   always_comb begin
      ctrl_view = '0;
      ctrl_view[PRE_W-1:0] = divisor;
      for (int i = 0; i < NUM_FLAGS; i++)
         ctrl_view[i+ENABLE_SHIFT] = en_vec[i];
   end

   always_comb begin
      rd_mux = '0;
      unique case (1'b1)
         hit_ctrl:   rd_mux = ctrl_view;
         hit_count:  rd_mux = DATA_W'(count);
         hit_alarm:  rd_mux = DATA_W'(alarm_val);
         hit_status: rd_mux = DATA_W'(flags);
         default:    rd_mux = '0;
      endcase
   end

   if (SNAPSHOT) begin : g_snap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     rd_data <= '0;
         else if (rd_en) rd_data <= rd_mux;
      end
   end else begin : g_direct
      assign rd_data = rd_en ? rd_mux : '0;
   end
endmodule

// File: rtl/uptime_alarm_timer.sv
module uptime_alarm_timer
   import uat_pkg::*;
#(
   parameter int          DATA_W    = 32,
   parameter int          ADDR_W    = 2,
   parameter int          CNT_W     = 32,
   parameter int          PRE_W     = 16,
   parameter int unsigned PRE_RESET = 32768,
   parameter bit          SNAPSHOT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr_en,
   input  logic [DATA_W-1:0] bus_wr_data,
   input  logic              bus_rd_en,
   output logic [DATA_W-1:0] bus_rd_data,
   output logic              irq
);
   if (DATA_W < RESTART_BIT + 1) begin : g_bad_data_w
      $error("DATA_W too narrow for control word");
   end
   if (CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("CNT_W exceeds DATA_W");
   end
   if (PRE_W < 1 || PRE_W > ENABLE_SHIFT) begin : g_bad_pre_w
      $error("PRE_W must lie in 1..16");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("ADDR_W must be at least 2");
   end
   if (PRE_RESET >= (64'd1 << PRE_W)) begin : g_bad_pre_reset
      $error("PRE_RESET does not fit PRE_W");
   end

   logic [PRE_W-1:0]     divisor;
   logic [NUM_FLAGS-1:0] en_vec, flags_q, set_vec;
   logic [CNT_W-1:0]     alarm_q, count_q;
   logic                 restart, status_clear, advance, alarm_hit;

   uat_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
      .PRE_W(PRE_W), .PRE_RESET(PRE_RESET), .SNAPSHOT(SNAPSHOT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr_en),
      .wr_data(bus_wr_data), .rd_en(bus_rd_en), .rd_data(bus_rd_data),
      .count(count_q), .flags(flags_q), .divisor(divisor), .en_vec(en_vec),
      .alarm_val(alarm_q), .restart(restart), .status_clear(status_clear)
   );

   uat_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .restart(restart),
      .divisor(divisor), .wrap(advance)
   );

   uat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .advance(advance), .restart(restart),
      .alarm_val(alarm_q), .count(count_q), .alarm_hit(alarm_hit)
   );

   always_comb begin
      set_vec           = '0;
      set_vec[FLAG_ALM] = alarm_hit;
      set_vec[FLAG_INC] = advance;
   end

   uat_status u_stat (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .en_vec(en_vec),
      .clear(status_clear), .flags(flags_q), .irq(irq)
   );
endmodule

// File: rtl/uat_chk.sv
module uat_chk
   import uat_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 2,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr_en,
   input logic [DATA_W-1:0] bus_wr_data,
   input logic              bus_rd_en,
   input logic [DATA_W-1:0] bus_rd_data,
   input logic              irq,
   input logic [CNT_W-1:0]  count_q,
   input logic [CNT_W-1:0]  alarm_q,
   input logic [1:0]        flags_q,
   input logic [1:0]        en_vec,
   input logic              advance
);
   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q != $past(count_q)) |-> (count_q == $past(count_q) + CNT_W'(1) || count_q == '0));

   // R4
   restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && bus_addr == ADDR_W'(SEL_CTRL) && bus_wr_data[RESTART_BIT]) |=> (count_q == '0));

   // R4
   restart_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_en && bus_addr == ADDR_W'(SEL_CTRL)) |=> !bus_rd_data[RESTART_BIT]);

   // R5
   inc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> flags_q[FLAG_INC]);

   // R6
   alarm_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_q[FLAG_ALM]) |-> (count_q == $past(alarm_q) && $past(alarm_q) != '1));

   // R7
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_en && bus_addr == ADDR_W'(SEL_STATUS) && !advance) |=> (flags_q == 2'b00));

   // R8
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|en_vec));
endmodule

bind uptime_alarm_timer uat_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
   .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
   .irq(irq), .count_q(count_q), .alarm_q(alarm_q), .flags_q(flags_q),
   .en_vec(en_vec), .advance(advance)
);

// File: tb/uptime_alarm_timer_test.sv
module uptime_alarm_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr_en = 1'b0;
   logic [31:0] bus_wr_data = '0;
   logic        bus_rd_en = 1'b0;
   logic [31:0] bus_rd_data;
   logic        irq;
   logic        rd_q = 1'b0;
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   typedef struct { logic [31:0] exp; string tag; } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;

   uptime_alarm_timer uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
      .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en),
      .bus_rd_data(bus_rd_data), .irq(irq)
   );

   always @(posedge clk) rd_q <= bus_rd_en;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rd_q) begin
         if (sb.size() == 0) chk("scoreboard empty", 32'h1, 32'h0);
         else begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, bus_rd_data, e.exp);
         end
      end
   end

   task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
      @(negedge clk);
      bus_addr = a; bus_rd_en = 1'b1;
      sb.push_back('{exp, tag});
      @(negedge clk);
      bus_rd_en = 1'b0;
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_en = 1'b1;
         @(negedge clk); tick_en = 1'b0;
      end
   endtask

   task automatic rd_with_tick(logic [31:0] exp, string tag);
      @(negedge clk);
      bus_addr = 2'd3; bus_rd_en = 1'b1; tick_en = 1'b1;
      sb.push_back('{exp, tag});
      @(negedge clk);
      bus_rd_en = 1'b0; tick_en = 1'b0;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 irq", {31'd0, irq}, 32'd0);
      rd(2'd0, 32'h0000_8000, "R1 ctrl");
      rd(2'd1, 32'd0, "R1 count");
      rd(2'd2, 32'hFFFF_FFFF, "R1 alarm");
      rd(2'd3, 32'd0, "R1 status");
      // R2 default divisor
      ticks(32767);
      rd(2'd1, 32'd0, "R2 count before wrap");
      ticks(1);
      rd(2'd1, 32'd1, "R2 count after wrap");
      rd(2'd3, 32'd2, "R5 inc flag");
      rd(2'd3, 32'd0, "R7 cleared");
      // R4 restart from mid phase, new divisor 3, inc enable
      ticks(5);
      wr(2'd0, (32'd1 << 18) | (32'd1 << 17) | 32'd3);
      rd(2'd1, 32'd0, "R4 count zeroed");
      rd(2'd0, 32'h0002_0003, "R4 ctrl readback");
      ticks(2);
      rd(2'd1, 32'd0, "R4 phase zeroed");
      chk("R8 irq quiet", {31'd0, irq}, 32'd0);
      ticks(1);
      chk("R8 irq inc", {31'd0, irq}, 32'd1);
      rd(2'd1, 32'd1, "R2 divisor 3");
      rd(2'd3, 32'd2, "R5 inc flag again");
      chk("R8 irq after clear", {31'd0, irq}, 32'd0);
      // R3 counter write ignored
      wr(2'd1, 32'h55);
      rd(2'd1, 32'd1, "R3 count unchanged");
      // R2 divisor 1 and 0
      wr(2'd0, (32'd1 << 18) | 32'd1);
      rd(2'd1, 32'd0, "R4 restart div1");
      ticks(5);
      rd(2'd1, 32'd5, "R2 divisor 1");
      wr(2'd0, (32'd1 << 18));
      ticks(3);
      rd(2'd1, 32'd3, "R2 divisor 0");
      // R6 alarm
      wr(2'd2, 32'd4);
      wr(2'd0, (32'd1 << 18) | (32'd1 << 16) | 32'd1);
      rd(2'd3, 32'd2, "R7 leftover inc");
      ticks(3);
      rd(2'd1, 32'd3, "R6 count 3");
      rd(2'd3, 32'd2, "R6 no alarm yet");
      chk("R8 inc masked", {31'd0, irq}, 32'd0);
      ticks(1);
      chk("R8 irq alarm", {31'd0, irq}, 32'd1);
      rd(2'd3, 32'd3, "R6 alarm flag");
      chk("R8 irq alarm cleared", {31'd0, irq}, 32'd0);
      rd(2'd3, 32'd0, "R6 no reassert");
      ticks(1);
      rd(2'd3, 32'd2, "R6 past alarm");
      // R7 collision
      rd_with_tick(32'd0, "R7 collision read");
      rd(2'd3, 32'd2, "R7 flag kept");
      // R9 snapshot
      rd(2'd1, 32'd6, "R9 count");
      ticks(3);
      @(negedge clk);
      chk("R9 held", bus_rd_data, 32'd6);
      rd(2'd1, 32'd9, "R9 new read");
      repeat (3) @(negedge clk);
      chk("scoreboard drained", sb.size(), 32'd0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule